// File: doc/BRIEF.md
# Single-Function Configuration Header with Base-Window Sizing

This block holds the 64-byte configuration header of one endpoint function. At reset the header is loaded from parameters: identity, class word, interrupt pin and the preset type bits of six base-address slots. A host reads the header 1, 2 or 4 bytes at a time from any byte offset. It writes only those fields whose offset and access width together allow it. A write to any other field is either refused with an error flag or dropped silently, as the rules below say.

Each base slot has a power-of-two span set by a parameter. Software finds the span by writing all ones and reading back the inverted span mask. It then programs an address. From that address the block forms a decoded window: the programmed value, with its low bits cleared, plus a fixed I/O or memory offset. A hit vector reports which windows contain the presented address. A hit needs the matching I/O-enable or memory-enable bit of the command field to be set. An expansion ROM slot follows a simpler sizing rule.

Access control is a two-state machine. In ST_IDLE the block raises `acc_ready`. An access presented there is taken (transition ACCEPT), and the machine moves to ST_RESP. In ST_RESP the block presents the registered read data and error flag for one cycle and then returns to ST_IDLE (transition RETIRE).

Top module: `cfg_header_space`

## Requirements
- R1: After reset the header holds the following values. Bytes 0x00-0x01 hold the vendor identity and 0x02-0x03 the device identity. 0x08-0x0B hold the class word. The six base slots at 0x10, 0x14, ... 0x24 hold their preset values. 0x3D holds the interrupt pin. Every other byte is zero.
- R2: A read of 1, 2 or 4 bytes returns the header bytes little-endian, starting at the offset, with the byte index wrapping modulo 64. Unused upper bytes are zero and `resp_err` is 0.
- R3: A 1-byte write is accepted only at 0x0C, 0x0D and 0x3C. At any other offset it sets `resp_err` and changes nothing.
- R4: A 2-byte write is accepted only at 0x04, 0x06 and 0x0C, where it writes two bytes. At any other offset it sets `resp_err` and changes nothing.
- R5: An access of any size other than 1, 2 or 4, read or write, sets `resp_err`, returns zero read data and changes nothing.
- R6: A 4-byte write of 0xFFFFFFFF to a base slot stores ~(2^L - 1) OR the preset type bits. L is the slot's span exponent. The type bits are bits [1:0] when preset bit 0 is 1 (I/O) and bits [3:0] otherwise (memory). The decoded window does not change.
- R7: Any other 4-byte write to a base slot stores the written value with the type bits replaced by their preset values.
- R8: A 4-byte write to 0x30 stores 0xFFFFFFFF when the value is 0xFFFFFFFE, and otherwise stores the value unchanged.
- R9: A 4-byte write to 0x04 stores only its low 16 bits. A 4-byte write to any other offset that is neither a base slot nor 0x30 changes nothing and does not set `resp_err`.
- R10: A non-probe write to a base slot loads a decoded base when the written value has a nonzero address part. For an I/O slot the address part is the value with bit 0 cleared, plus `IO_WINDOW`. For a memory slot it is the value with bits [1:0] cleared, plus `MEM_WINDOW`. The new base replaces the previous one. A write whose address part is zero leaves the base as it was.
- R11: `bar_hit[i]` is 1 exactly when all three hold: slot i's decoded base is nonzero; base <= `hit_addr` <= base + 2^L - 1; and the command bit for the slot's kind is set (bit 0 for I/O, bit 1 for memory, at byte 0x04).
- R12: `acc_ready` is high in ST_IDLE. An access accepted there is answered by `resp_valid` high for exactly the next cycle, together with `rd_data` and `resp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Block can take an access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access width in bytes |
| acc_offset | input | 6 | Byte offset into the header |
| acc_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| resp_valid | output | 1 | Response cycle |
| resp_err | output | 1 | Access refused |
| rd_data | output | 32 | Read data, little-endian |
| hit_addr | input | 32 | Address compared with the decoded windows |
| bar_hit | output | 6 | Per-slot window hit |

## Verification
The case hardest to reach from the ports is a window that keeps its old range while its register changes. A probe, or a write whose address part is zero, updates the register but not the decoded base. Only a later hit check can show the difference. The bench therefore programs every slot, probes or zero-writes selected slots, and then checks hits at both window edges and one address beyond each edge. It also sweeps every offset at every width against an arithmetic model of the header, and toggles each command enable so that each half of the hit condition is tested on its own.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

    localparam int          NUM_BARS   = 6;
    localparam logic [5:0]  OFF_CMD    = 6'h04;
    localparam logic [5:0]  OFF_STAT   = 6'h06;
    localparam logic [5:0]  OFF_CLS    = 6'h0C;
    localparam logic [5:0]  OFF_LAT    = 6'h0D;
    localparam logic [3:0]  WORD_BAR0  = 4'd4;
    localparam logic [5:0]  OFF_ROM    = 6'h30;
    localparam logic [5:0]  OFF_INTLN  = 6'h3C;
endpackage

// File: rtl/cfg_write_policy.sv
module cfg_write_policy
    import cfg_hdr_pkg::*;
(
    input  logic [2:0]  acc_size,
    input  logic [5:0]  acc_off,
    input  logic [31:0] wdata,
    input  logic [31:0] old_word,
    input  logic [4:0]  bar_log2,
    output logic        size_ok,
    output logic        wr_err,
    output logic [3:0]  lanes,
    output logic [31:0] new_word,
    output logic        bar_load
);
    logic        is_bar;
    logic [31:0] type_m;
    logic [31:0] span_m1;

    assign size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
    assign is_bar  = (acc_off[1:0] == 2'b00) && (acc_off[5:2] >= WORD_BAR0)
                   && (acc_off[5:2] <= WORD_BAR0 + 4'd5);
    assign type_m  = old_word[0] ? 32'h3 : 32'hF;
    assign span_m1 = (32'h1 << bar_log2) - 32'h1;

    always_comb begin
        wr_err   = 1'b0;
        lanes    = 4'b0000;
        new_word = wdata << {acc_off[1:0], 3'b000};
        bar_load = 1'b0;
        unique case (acc_size)
            3'd1: begin
                if (acc_off == OFF_CLS || acc_off == OFF_LAT || acc_off == OFF_INTLN)
                    lanes = 4'b0001 << acc_off[1:0];
                else
                    wr_err = 1'b1;
            end
            3'd2: begin
                if (acc_off == OFF_CMD || acc_off == OFF_STAT || acc_off == OFF_CLS)
                    lanes = 4'b0011 << acc_off[1:0];
                else
                    wr_err = 1'b1;
            end
            3'd4: begin
                if (is_bar) begin
                    lanes = 4'b1111;
                    if (wdata == 32'hFFFF_FFFF) begin
                        new_word = ~span_m1 | (old_word & type_m);
                    end else begin
                        new_word = (wdata & ~type_m) | (old_word & type_m);
                        bar_load = 1'b1;
                    end
                end else if (acc_off == OFF_ROM) begin
                    lanes    = 4'b1111;
                    new_word = (wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wdata;
                end else if (acc_off == OFF_CMD) begin
                    lanes    = 4'b0011;
                    new_word = wdata;
                end
            end
            default: wr_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfg_bar_window.sv
module cfg_bar_window #(
    parameter bit          IS_IO     = 1'b0,
    parameter int          SPAN_LOG2 = 12,
    parameter logic [31:0] WINDOW    = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] wdata,
    input  logic        space_en,
    input  logic [31:0] addr,
    output logic        hit
);
    localparam logic [32:0] SPAN    = 33'h1 << SPAN_LOG2;
    localparam logic [31:0] CLR_M   = IS_IO ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;

    logic [31:0] base_q;
    logic [31:0] addr_part;
    logic [31:0] delta;

    assign addr_part = wdata & CLR_M;

    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (load && addr_part != 32'h0)
            base_q <= addr_part + WINDOW;
    end

    assign delta = addr - base_q;
    assign hit   = space_en && (base_q != 32'h0) && (addr >= base_q)
                && ({1'b0, delta} < SPAN);
endmodule

// File: rtl/cfg_header_space.sv
module cfg_header_space
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0]       VENDOR_ID  = 16'h5A5A,
    parameter logic [15:0]       DEVICE_ID  = 16'hC0DE,
    parameter logic [31:0]       CLASS_WORD = 32'h0200_0001,
    parameter logic [7:0]        INT_PIN    = 8'h01,
    parameter logic [5:0][31:0]  BAR_PRESET = {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
    parameter logic [5:0][4:0]   BAR_LOG2   = {5'd4, 5'd5, 5'd6, 5'd16, 5'd8, 5'd12},
    parameter logic [31:0]       IO_WINDOW  = 32'h0001_0000,
    parameter logic [31:0]       MEM_WINDOW = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    output logic        acc_ready,
    input  logic        acc_write,
    input  logic [2:0]  acc_size,
    input  logic [5:0]  acc_offset,
    input  logic [31:0] acc_wdata,
    output logic        resp_valid,
    output logic        resp_err,
    output logic [31:0] rd_data,
    input  logic [31:0] hit_addr,
    output logic [5:0]  bar_hit
);
    acc_state_e  state_q, state_d;
    logic [31:0] img_q [16];
    logic [31:0] rd_q;
    logic        err_q;
    logic        accept;
    logic [3:0]  widx;
    logic [4:0]  sel_log2;
    logic        size_ok, wr_err, bar_load;
    logic [3:0]  lanes;
    logic [31:0] new_word;
    logic [31:0] rd_next;
    logic [5:0]  bidx;

    function automatic logic [31:0] reset_word(input int w);
        logic [31:0] v;
        v = 32'h0;
        if (w == 0)  v = {DEVICE_ID, VENDOR_ID};
        if (w == 2)  v = CLASS_WORD;
        if (w == 15) v = {16'h0, INT_PIN, 8'h00};
        for (int i = 0; i < NUM_BARS; i++)
            if (w == i + 4) v = BAR_PRESET[i];
        return v;
    endfunction

    assign accept = acc_valid && (state_q == ST_IDLE);
    assign widx   = acc_offset[5:2];

    always_comb begin
        sel_log2 = 5'd4;
        for (int i = 0; i < NUM_BARS; i++)
            if (widx == WORD_BAR0 + 4'(i)) sel_log2 = BAR_LOG2[i];
    end

    cfg_write_policy u_policy (
        .acc_size (acc_size),
        .acc_off  (acc_offset),
        .wdata    (acc_wdata),
        .old_word (img_q[widx]),
        .bar_log2 (sel_log2),
        .size_ok  (size_ok),
        .wr_err   (wr_err),
        .lanes    (lanes),
        .new_word (new_word),
        .bar_load (bar_load)
    );

    always_comb begin
        rd_next = '0;
        bidx    = '0;
        for (int b = 0; b < 4; b++) begin
            bidx = acc_offset + 6'(b);
            if (size_ok && (3'(b) < acc_size))
                rd_next[8*b +: 8] = img_q[bidx[5:2]][{bidx[1:0], 3'b000} +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acc_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        resp_err   = err_q;
        rd_data    = rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            err_q <= 1'b0;
            for (int w = 0; w < 16; w++) img_q[w] <= reset_word(w);
        end else if (accept) begin
            rd_q  <= acc_write ? 32'h0 : rd_next;
            err_q <= acc_write ? wr_err : !size_ok;
            if (acc_write)
                for (int l = 0; l < 4; l++)
                    if (lanes[l]) img_q[widx][8*l +: 8] <= new_word[8*l +: 8];
        end
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        cfg_bar_window #(
            .IS_IO     (BAR_PRESET[g][0]),
            .SPAN_LOG2 (int'(BAR_LOG2[g])),
            .WINDOW    (BAR_PRESET[g][0] ? IO_WINDOW : MEM_WINDOW)
        ) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept && acc_write && bar_load && (widx == WORD_BAR0 + 4'(g))),
            .wdata    (acc_wdata),
            .space_en (BAR_PRESET[g][0] ? img_q[1][0] : img_q[1][1]),
            .addr     (hit_addr),
            .hit      (bar_hit[g])
        );
    end
endmodule

// File: rtl/cfg_header_space_chk.sv
module cfg_header_space_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_ready,
    input logic        acc_write,
    input logic [2:0]  acc_size,
    input logic        resp_valid,
    input logic        resp_err,
    input logic [31:0] rd_data,
    input logic [5:0]  bar_hit,
    input logic [1:0]  cmd_en
);
    // R12
    accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> resp_valid);

    // R12
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && acc_ready));

    // R5
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_size == 3'd3) |=> (resp_err && rd_data == 32'h0));

    // R2
    byte_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write && acc_size == 3'd1) |=> (rd_data[31:8] == 24'h0 && !resp_err));

    // R11
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_hit != 6'h0) |-> (cmd_en != 2'b00));
endmodule

bind cfg_header_space cfg_header_space_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_write  (acc_write),
    .acc_size   (acc_size),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .rd_data    (rd_data),
    .bar_hit    (bar_hit),
    .cmd_en     (img_q[1][1:0])
);

// File: tb/cfg_header_space_tb.sv
`timescale 1ns/1ps
module cfg_header_space_tb;
    localparam logic [31:0] PRE   [6] = '{32'h0, 32'h1, 32'h8, 32'h0, 32'h0, 32'h0};
    localparam int          LOG2  [6] = '{12, 8, 16, 6, 5, 4};
    localparam logic [31:0] IOW   = 32'h0001_0000;
    localparam logic [31:0] MEMW  = 32'h4000_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_size = 3'd0;
    logic [5:0]  acc_offset = 6'd0;
    logic [31:0] acc_wdata = 32'h0, hit_addr = 32'h0;
    logic        acc_ready, resp_valid, resp_err;
    logic [31:0] rd_data;
    logic [5:0]  bar_hit;

    int checks = 0, errors = 0;
    logic [7:0]  m [64];
    logic [31:0] base [6];
    logic [31:0] rd;
    logic        er;

    always #2.5 clk = ~clk;

    cfg_header_space u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_size(acc_size), .acc_offset(acc_offset),
        .acc_wdata(acc_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
        .rd_data(rd_data), .hit_addr(hit_addr), .bar_hit(bar_hit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [2:0] sz, input logic [5:0] off,
                       input logic [31:0] wd, output logic [31:0] r, output logic e);
        @(negedge clk);
        chk(acc_ready, "R12 ready in idle", 32'(acc_ready), 32'h1);
        acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_offset = off; acc_wdata = wd;
        @(negedge clk);
        chk(resp_valid, "R12 response cycle", 32'(resp_valid), 32'h1);
        r = rd_data; e = resp_err;
        acc_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_rd(input int sz, input int off);
        logic [31:0] v;
        v = 32'h0;
        for (int b = 0; b < sz; b++) v[8*b +: 8] = m[(off + b) % 64];
        return v;
    endfunction

    function automatic logic [31:0] mword(input int w);
        return {m[4*w+3], m[4*w+2], m[4*w+1], m[4*w]};
    endfunction

    task automatic set_word(input int w, input logic [31:0] v);
        for (int b = 0; b < 4; b++) m[4*w+b] = v[8*b +: 8];
    endtask

    task automatic image_check(input string tag);
        for (int w = 0; w < 16; w++) begin
            acc(1'b0, 3'd4, 6'(4*w), 32'h0, rd, er);
            chk(rd == mword(w) && !er, tag, rd, mword(w));
        end
    endtask

    task automatic hit_chk(input logic [31:0] a, input logic [5:0] exp, input string tag);
        @(negedge clk);
        hit_addr = a;
        #1;
        chk(bar_hit == exp, tag, 32'(bar_hit), 32'(exp));
    endtask

    function automatic logic [31:0] tmask(input int i);
        return PRE[i][0] ? 32'h3 : 32'hF;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) m[k] = 8'h0;
        set_word(0, {16'hC0DE, 16'h5A5A});
        set_word(2, 32'h0200_0001);
        for (int i = 0; i < 6; i++) set_word(4 + i, PRE[i]);
        m[8'h3D] = 8'h01;
        for (int i = 0; i < 6; i++) base[i] = 32'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!resp_valid && acc_ready, "R12 reset idle", 32'(resp_valid), 32'h0);
        chk(bar_hit == 6'h0, "R11 reset no hits", 32'(bar_hit), 32'h0);

        // R1 reset image, R2 read widths and wrap
        image_check("R1 reset image");
        for (int o = 0; o < 64; o++) begin
            acc(1'b0, 3'd1, 6'(o), 32'h0, rd, er);
            chk(rd == exp_rd(1, o) && !er, "R2 byte read", rd, exp_rd(1, o));
        end
        for (int o = 0; o < 64; o += 3) begin
            acc(1'b0, 3'd2, 6'(o), 32'h0, rd, er);
            chk(rd == exp_rd(2, o) && !er, "R2 half read", rd, exp_rd(2, o));
            acc(1'b0, 3'd4, 6'(o), 32'h0, rd, er);
            chk(rd == exp_rd(4, o) && !er, "R2 word read", rd, exp_rd(4, o));
        end

        // R3 one-byte write permission sweep
        for (int o = 0; o < 64; o++) begin
            logic ok;
            ok = (o == 12) || (o == 13) || (o == 60);
            acc(1'b1, 3'd1, 6'(o), 32'(o ^ 8'hA5), rd, er);
            chk(er == !ok, "R3 byte write err", 32'(er), 32'(!ok));
            if (ok) m[o] = 8'(o ^ 8'hA5);
        end
        image_check("R3 image after byte writes");

        // R4 two-byte write permission sweep
        for (int o = 0; o < 64; o++) begin
            logic ok;
            ok = (o == 4) || (o == 6) || (o == 12);
            acc(1'b1, 3'd2, 6'(o), {16'h0, 8'(o), 8'(~o)}, rd, er);
            chk(er == !ok, "R4 half write err", 32'(er), 32'(!ok));
            if (ok) begin m[o] = 8'(~o); m[o+1] = 8'(o); end
        end
        image_check("R4 image after half writes");

        // R5 illegal sizes
        for (int s = 0; s < 8; s++) begin
            if (s == 1 || s == 2 || s == 4) continue;
            acc(1'b1, 3'(s), 6'h0C, 32'h7777_7777, rd, er);
            chk(er, "R5 bad-size write err", 32'(er), 32'h1);
            acc(1'b0, 3'(s), 6'h00, 32'h0, rd, er);
            chk(er && rd == 32'h0, "R5 bad-size read", rd, 32'h0);
        end
        image_check("R5 image unchanged");

        // R9 word writes to plain fields ignored; command takes low half
        for (int w = 0; w < 16; w++) begin
            if (w == 1 || (w >= 4 && w <= 9) || w == 12) continue;
            acc(1'b1, 3'd4, 6'(4*w), 32'hDEAD_BEEF, rd, er);
            chk(!er, "R9 ignored write no err", 32'(er), 32'h0);
        end
        acc(1'b1, 3'd4, 6'h04, 32'h1234_0000, rd, er);
        m[4] = 8'h00; m[5] = 8'h00;
        image_check("R9 image after word writes");

        // R6 probes
        for (int i = 0; i < 6; i++) begin
            logic [31:0] e;
            e = ~((32'h1 << LOG2[i]) - 1) | (PRE[i] & tmask(i));
            acc(1'b1, 3'd4, 6'(16 + 4*i), 32'hFFFF_FFFF, rd, er);
            acc(1'b0, 3'd4, 6'(16 + 4*i), 32'h0, rd, er);
            chk(rd == e, "R6 probe readback", rd, e);
            set_word(4 + i, e);
        end

        // R11 enabled but never assigned: no hits
        acc(1'b1, 3'd2, 6'h04, 32'h0000_0003, rd, er);
        m[4] = 8'h03; m[5] = 8'h00;
        hit_chk(32'h0, 6'h0, "R11 unassigned at zero");
        hit_chk(MEMW, 6'h0, "R11 unassigned at window");
        hit_chk(32'hFFFF_FFFF, 6'h0, "R11 unassigned at top");

        // R7 R10 R11 program each slot and check edges
        for (int i = 0; i < 6; i++) begin
            logic [31:0] v, e, span;
            v    = ((i + 1) << 20) | 32'h5;
            e    = (v & ~tmask(i)) | (PRE[i] & tmask(i));
            span = 32'h1 << LOG2[i];
            base[i] = PRE[i][0] ? ((v & ~32'h1) + IOW) : ((v & ~32'h3) + MEMW);
            acc(1'b1, 3'd4, 6'(16 + 4*i), v, rd, er);
            acc(1'b0, 3'd4, 6'(16 + 4*i), 32'h0, rd, er);
            chk(rd == e, "R7 programmed readback", rd, e);
            set_word(4 + i, e);
        end
        for (int i = 0; i < 6; i++) begin
            logic [31:0] span;
            span = 32'h1 << LOG2[i];
            hit_chk(base[i], 6'(1 << i), "R11 hit at base");
            hit_chk(base[i] + span - 1, 6'(1 << i), "R11 hit at last byte");
            hit_chk(base[i] - 1, 6'h0, "R11 miss below base");
            hit_chk(base[i] + span, 6'h0, "R11 miss past end");
        end

        // R11 enable bits
        acc(1'b1, 3'd4, 6'h04, 32'h0000_0001, rd, er);
        hit_chk(base[1], 6'h02, "R11 io only: io hits");
        hit_chk(base[0], 6'h00, "R11 io only: mem masked");
        acc(1'b1, 3'd4, 6'h04, 32'h0000_0002, rd, er);
        hit_chk(base[1], 6'h00, "R11 mem only: io masked");
        hit_chk(base[2], 6'h04, "R11 mem only: mem hits");
        acc(1'b1, 3'd4, 6'h04, 32'h0000_0003, rd, er);

        // R10 zero address part keeps base; probe keeps base; rebase replaces
        acc(1'b1, 3'd4, 6'h10, 32'h0000_0003, rd, er);
        acc(1'b0, 3'd4, 6'h10, 32'h0, rd, er);
        chk(rd == 32'h0, "R7 zero write readback", rd, 32'h0);
        hit_chk(base[0], 6'h01, "R10 zero write keeps window");
        acc(1'b1, 3'd4, 6'h14, 32'hFFFF_FFFF, rd, er);
        hit_chk(base[1], 6'h02, "R10 probe keeps window");
        acc(1'b1, 3'd4, 6'h10, 32'h0030_0000, rd, er);
        hit_chk(base[0], 6'h00, "R10 old window dropped");
        hit_chk(32'h0030_0000 + MEMW, 6'h01, "R10 new window");

        // R8 expansion ROM rule
        acc(1'b1, 3'd4, 6'h30, 32'hFFFF_FFFE, rd, er);
        acc(1'b0, 3'd4, 6'h30, 32'h0, rd, er);
        chk(rd == 32'hFFFF_FFFF, "R8 rom sizing", rd, 32'hFFFF_FFFF);
        acc(1'b1, 3'd4, 6'h30, 32'h1234_5679, rd, er);
        acc(1'b0, 3'd4, 6'h30, 32'h0, rd, er);
        chk(rd == 32'h1234_5679, "R8 rom plain", rd, 32'h1234_5679);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule